// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This engine moves incoming frames from a byte stream into memory buffers. Software describes each buffer with a three-word receive descriptor. The descriptors sit back to back in a ring in word-addressed memory. For every frame the engine first reads the current descriptor. If hardware owns it, the engine packs the frame bytes into 32-bit words and writes them to the buffer. It then writes the received length back into the descriptor and returns the descriptor to software with an error flag. Finally it moves on to the next descriptor, or back to the ring base when the current one carries the end-of-list mark.

A receive-request bit gates the engine. Software sets and clears it with one-cycle pulses. The engine clears it by itself when a frame arrives and the current descriptor still belongs to software. In that case the frame is consumed and discarded, and the ring pointer stays where it is, so software can re-arm the descriptor and set the bit again. The memory port is always ready and returns read data one cycle after the request.

Top module: `rxd_dma`

## Requirements
- R1: Descriptor layout at word offsets +0, +1 and +2 from its start.
  - Word 0 is the flags word: bit 31 means owned by hardware, bit 30 marks end of list, and bit 27 is the frame-error flag.
  - Word 1 bits 31:16 hold the buffer capacity in bytes, and bits 15:0 hold the received length.
  - Word 2 holds the buffer byte address.
- R2: After reset, rx_req, in_ready and mem_en are all 0, and the ring pointer equals ring_base.
- R3: A frame starts only while rx_req is 1 and in_valid is 1. The engine then reads descriptor words +0, +1 and +2 in three consecutive cycles, starting at the current descriptor.
- R4: Stored byte i of a frame goes to word (buffer address >> 2) + i/4, in bits 8*(i%4)+7 : 8*(i%4). Lanes of the last, partly filled word that receive no byte are written as zero.
- R5: The low five bits of the buffer byte address are ignored, because buffers are aligned to 32 bytes.
- R6: After the last byte, the engine writes word 1 back with the capacity unchanged and the length equal to the number of bytes stored. It then writes word 0 with bit 31 cleared and bit 27 set to the frame error. All other bits of word 0 keep their values.
- R7: The frame-error bit is 1 if in_err is high with the last byte, or if the frame is longer than the capacity. Otherwise it is 0.
- R8: A frame longer than the capacity is truncated to the capacity. The extra bytes are accepted but never written to memory.
- R9: After a descriptor is returned, the next frame uses the descriptor three words further on. If the returned descriptor has bit 30 set, the next frame uses ring_base instead.
- R10: If word 0 of the current descriptor has bit 31 clear, the frame is consumed without any memory write, rx_req is cleared, and the ring pointer is unchanged.
- R11: rx_req_set sets rx_req and rx_req_clr clears it. While rx_req is 0, in_ready stays 0 and no frame starts.
- R12: in_ready is 1 only in the data phase. A frame offered without gaps is stalled for exactly five cycles before its first byte if the descriptor is owned, and for three cycles if it is not. After that it is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Word address of the first descriptor |
| rx_req_set | input | 1 | Pulse that sets the receive-request bit |
| rx_req_clr | input | 1 | Pulse that clears the receive-request bit |
| rx_req | output | 1 | Receive-request bit |
| in_valid | input | 1 | Byte offered on in_data |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the last byte of a frame |
| in_err | input | 1 | Frame error, sampled with the last byte |
| in_ready | output | 1 | Engine accepts the offered byte |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |

## Verification
The engine is tried with a range of frames:
- A nine-byte frame into a large buffer, which checks lane packing and the zero-filled tail of the last word.
- A ten-byte frame into a six-byte buffer whose address has garbage in its low bits. It separates truncation and the overflow error from plain alignment masking, and shows whether a word beyond the cut is left untouched.
- A four-byte frame with in_err at the last byte, stored into the end-of-list descriptor. It isolates the input-error path and the wrap.
- An exactly full eight-byte buffer, which checks that a capacity-sized frame raises no error.

Frames that meet a descriptor still owned by software tell dropping apart from storing, and show the pointer staying in place. A phase with rx_req clear shows that the gate holds the stream off entirely.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   // flags word bit positions
   localparam int OWN_BIT    = 31;
   localparam int WRAP_BIT   = 30;
   localparam int BAD_BIT    = 27;
   // words per descriptor and width of the length field
   localparam int DESC_WORDS = 3;
   localparam int LEN_W      = 16;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH0,
      ST_FETCH1,
      ST_FETCH2,
      ST_FETCH3,
      ST_FILL,
      ST_SKIP,
      ST_PUT_LEN,
      ST_PUT_FLAGS
   } rxd_state_e;
endpackage

// File: rtl/rxd_ring_ptr.sv
// Descriptor pointer kept as an offset from the ring base.
module rxd_ring_ptr #(
   parameter int AW     = 16,
   parameter int STRIDE = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] base,
   input  logic          step,
   input  logic          wrap,
   output logic [AW-1:0] cur
);
   logic [AW-1:0] off_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         off_q <= '0;
      else if (step)
         off_q <= wrap ? '0 : off_q + AW'(STRIDE);
   end

   assign cur = base + off_q;
endmodule

// File: rtl/rxd_packer.sv
// Packs accepted bytes into 32-bit words, bounded by the buffer capacity.
module rxd_packer #(
   parameter int LEN_W      = 16,
   parameter int LANE_ORDER = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             take,
   input  logic [7:0]       in_byte,
   input  logic             last,
   input  logic             err_in,
   input  logic [LEN_W-1:0] cap,
   output logic [LEN_W-1:0] stored,
   output logic             wr,
   output logic [LEN_W-3:0] wr_idx,
   output logic [31:0]      wr_data,
   output logic             bad
);
   logic [31:0]      hold_q;
   logic [LEN_W-1:0] cnt_q;
   logic             bad_q;
   logic [1:0]       lane;
   logic             keep, full, fin, flush;

   generate
      if (LANE_ORDER == 0) begin : g_low_first
         assign lane = cnt_q[1:0];
      end else begin : g_high_first
         assign lane = 2'd3 - cnt_q[1:0];
      end
   endgenerate

   assign keep = take && (cnt_q < cap);
   assign full = keep && (cnt_q[1:0] == 2'd3);
   assign fin  = take && last;
   // an over-long frame may end with a partial word still held
   assign flush = fin && !keep && (cnt_q[1:0] != 2'd0);

   always_comb begin
      wr_data = hold_q;
      if (keep)
         wr_data[{lane, 3'b000} +: 8] = in_byte;
   end

   assign wr     = full || (fin && keep) || flush;
   assign wr_idx = cnt_q[LEN_W-1:2];
   assign stored = cnt_q;
   assign bad    = bad_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         hold_q <= '0;
         cnt_q  <= '0;
         bad_q  <= 1'b0;
      end else if (take) begin
         if (keep)
            cnt_q <= cnt_q + LEN_W'(1);
         hold_q <= full ? '0 : wr_data;
         bad_q  <= bad_q | !keep | (last & err_in);
      end
   end
endmodule

// File: rtl/rxd_dma.sv
module rxd_dma
   import rxd_pkg::*;
#(
   parameter int AW          = 16,
   parameter int ALIGN_WORDS = 8,
   parameter int LANE_ORDER  = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ring_base,
   input  logic          rx_req_set,
   input  logic          rx_req_clr,
   output logic          rx_req,
   input  logic          in_valid,
   input  logic [7:0]    in_data,
   input  logic          in_last,
   input  logic          in_err,
   output logic          in_ready,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata
);
   localparam int IDX_W = LEN_W - 2;

   generate
      if (AW < 8 || AW > 29) begin : g_bad_aw
         $error("rxd_dma: AW must lie in 8..29");
      end
      if (ALIGN_WORDS < 1 || (ALIGN_WORDS & (ALIGN_WORDS - 1)) != 0) begin : g_bad_align
         $error("rxd_dma: ALIGN_WORDS must be a power of two");
      end
      if (LANE_ORDER < 0 || LANE_ORDER > 1) begin : g_bad_order
         $error("rxd_dma: LANE_ORDER must be 0 or 1");
      end
   endgenerate

   rxd_state_e       state, state_d;
   logic [31:0]      flags_q;
   logic [LEN_W-1:0] cap_q;
   logic [AW-1:0]    buf_q;
   logic [AW-1:0]    cur;
   logic             rx_req_q;
   logic             take, step, drop_clr, pk_clear, pk_wr, pk_bad;
   logic [LEN_W-1:0] stored_cnt;
   logic [IDX_W-1:0] pk_idx;
   logic [31:0]      pk_data;

   assign in_ready = (state == ST_FILL) || (state == ST_SKIP);
   assign take     = in_valid && in_ready;
   assign pk_clear = (state == ST_FETCH3);
   assign rx_req   = rx_req_q;

   rxd_ring_ptr #(
      .AW     (AW),
      .STRIDE (DESC_WORDS)
   ) u_ring (
      .clk   (clk),
      .rst_n (rst_n),
      .base  (ring_base),
      .step  (step),
      .wrap  (flags_q[WRAP_BIT]),
      .cur   (cur)
   );

   rxd_packer #(
      .LEN_W      (LEN_W),
      .LANE_ORDER (LANE_ORDER)
   ) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (pk_clear),
      .take    (take),
      .in_byte (in_data),
      .last    (in_last),
      .err_in  (in_err),
      .cap     (cap_q),
      .stored  (stored_cnt),
      .wr      (pk_wr),
      .wr_idx  (pk_idx),
      .wr_data (pk_data),
      .bad     (pk_bad)
   );

   always_comb begin
      state_d   = state;
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur;
      mem_wdata = pk_data;
      step      = 1'b0;
      drop_clr  = 1'b0;
      case (state)
         ST_IDLE: begin
            if (rx_req_q && in_valid)
               state_d = ST_FETCH0;
         end
         ST_FETCH0: begin
            mem_en  = 1'b1;
            state_d = ST_FETCH1;
         end
         ST_FETCH1: begin
            mem_en   = 1'b1;
            mem_addr = cur + AW'(1);
            if (mem_rdata[OWN_BIT]) begin
               state_d = ST_FETCH2;
            end else begin
               state_d  = ST_SKIP;
               drop_clr = 1'b1;
            end
         end
         ST_FETCH2: begin
            mem_en   = 1'b1;
            mem_addr = cur + AW'(2);
            state_d  = ST_FETCH3;
         end
         ST_FETCH3: begin
            state_d = ST_FILL;
         end
         ST_FILL: begin
            mem_en   = pk_wr;
            mem_we   = pk_wr;
            mem_addr = buf_q + AW'(pk_idx);
            if (take && in_last)
               state_d = ST_PUT_LEN;
         end
         ST_SKIP: begin
            if (take && in_last)
               state_d = ST_IDLE;
         end
         ST_PUT_LEN: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur + AW'(1);
            mem_wdata = {cap_q, stored_cnt};
            state_d   = ST_PUT_FLAGS;
         end
         ST_PUT_FLAGS: begin
            mem_en             = 1'b1;
            mem_we             = 1'b1;
            mem_wdata          = flags_q;
            mem_wdata[OWN_BIT] = 1'b0;
            mem_wdata[BAD_BIT] = pk_bad;
            step               = 1'b1;
            state_d            = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         flags_q  <= '0;
         cap_q    <= '0;
         buf_q    <= '0;
         rx_req_q <= 1'b0;
      end else begin
         state <= state_d;
         if (state == ST_FETCH1)
            flags_q <= mem_rdata;
         if (state == ST_FETCH2)
            cap_q <= mem_rdata[31:32-LEN_W];
         if (state == ST_FETCH3)
            buf_q <= mem_rdata[AW+1:2] & ~AW'(ALIGN_WORDS - 1);
         if (rx_req_set)
            rx_req_q <= 1'b1;
         else if (rx_req_clr || drop_clr)
            rx_req_q <= 1'b0;
      end
   end
endmodule

// File: rtl/rxd_dma_chk.sv
module rxd_dma_chk
   import rxd_pkg::*;
#(
   parameter int AW = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_req_set,
   input logic             rx_req,
   input logic             in_ready,
   input logic             mem_en,
   input logic             mem_we,
   input logic [AW-1:0]    mem_addr,
   input logic [31:0]      mem_wdata,
   input logic [31:0]      mem_rdata,
   input rxd_state_e       state,
   input logic [LEN_W-1:0] stored_cnt,
   input logic [LEN_W-1:0] cap_q,
   input logic [AW-1:0]    buf_q
);
   // R10
   drop_clears_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FETCH1 && !mem_rdata[OWN_BIT] && !rx_req_set) |=> !rx_req);

   // R8
   stored_within_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL) |-> (stored_cnt <= cap_q));

   // R4
   fill_inside_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && mem_en) |-> (mem_we && mem_addr >= buf_q));

   // R6
   release_clears_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PUT_FLAGS) |-> (mem_en && mem_we && !mem_wdata[OWN_BIT]));

   // R12
   no_read_in_data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !(mem_en && !mem_we));

   // R11
   idle_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !rx_req) |=> (state == ST_IDLE));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (!mem_en && !in_ready));
endmodule

bind rxd_dma rxd_dma_chk #(.AW(AW)) u_rxd_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_req_set (rx_req_set),
   .rx_req     (rx_req),
   .in_ready   (in_ready),
   .mem_en     (mem_en),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_rdata  (mem_rdata),
   .state      (state),
   .stored_cnt (stored_cnt),
   .cap_q      (cap_q),
   .buf_q      (buf_q)
);

// File: tb/test_rxd_dma.sv
module test_rxd_dma;
   localparam int AW   = 16;
   localparam int BASE = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ring_base = AW'(BASE);
   logic          rx_req_set = 1'b0, rx_req_clr = 1'b0, rx_req;
   logic          in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0, in_ready;
   logic [7:0]    in_data = '0;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_wdata, mem_rdata;

   logic [31:0] mem     [0:1023];
   logic [31:0] exp_mem [0:1023];
   bit          allow   [0:1023];
   logic        tb_we = 1'b0;
   logic [9:0]  tb_addr = '0;
   logic [31:0] tb_data = '0;

   int vectors = 0, miscompares = 0;
   int exp_off = 0, rd_idx = 0;
   bit exp_req = 0, done = 0;

   always #10 clk = ~clk;

   rxd_dma #(.AW(AW)) i_rxd_dma (
      .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
      .rx_req_set(rx_req_set), .rx_req_clr(rx_req_clr), .rx_req(rx_req),
      .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_err(in_err),
      .in_ready(in_ready), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // word memory, one-cycle read latency
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) mem[i] <= '0;
      end else if (tb_we) begin
         mem[tb_addr] <= tb_data;
      end else if (mem_en && mem_we) begin
         mem[mem_addr[9:0]] <= mem_wdata;
      end
      if (mem_en && !mem_we)
         mem_rdata <= mem[mem_addr[9:0]];
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   // every memory access checked against the model
   always @(negedge clk) begin
      #2;
      if (rst_n && mem_en) begin
         if (mem_we) begin
            chk(mem_addr < 1024 && allow[mem_addr[9:0]] && mem_wdata == exp_mem[mem_addr[9:0]],
                $sformatf("R4 R6 write @%0d", mem_addr), mem_wdata, exp_mem[mem_addr[9:0]]);
         end else begin
            chk(mem_addr == AW'(BASE + exp_off + rd_idx), "R3 read order",
                {16'h0, mem_addr}, BASE + exp_off + rd_idx);
            rd_idx++;
         end
      end
   end

   task automatic put(input int a, input logic [31:0] d);
      exp_mem[a] = d;
      @(negedge clk);
      tb_we = 1'b1; tb_addr = 10'(a); tb_data = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic pulse_set();
      @(negedge clk); rx_req_set = 1'b1;
      @(negedge clk); rx_req_set = 1'b0;
      exp_req = 1;
   endtask

   task automatic pulse_clr();
      @(negedge clk); rx_req_clr = 1'b1;
      @(negedge clk); rx_req_clr = 1'b0;
      exp_req = 0;
   endtask

   // plan the expected memory image, send the frame, compare
   task automatic run_frame(input logic [7:0] q[$], input bit e, input string tag);
      int d, cap, bw, n, st, stalls, diffs;
      bit owned, bad, r;
      logic [31:0] w0;
      d = BASE + exp_off;
      rd_idx = 0;
      for (int i = 0; i < 1024; i++) allow[i] = 0;
      w0 = exp_mem[d];
      owned = w0[31];
      n = q.size();
      if (owned) begin
         cap = int'(exp_mem[d+1][31:16]);
         bw  = int'(exp_mem[d+2] >> 2) & ~7;      // R5
         st  = (n < cap) ? n : cap;               // R8
         for (int i = 0; i < st; i++) begin
            if (i % 4 == 0) exp_mem[bw + i/4] = '0;
            exp_mem[bw + i/4][8*(i%4) +: 8] = q[i];
            allow[bw + i/4] = 1;
         end
         bad = e || (n > cap);                    // R7
         exp_mem[d+1] = {cap[15:0], st[15:0]};
         w0[31] = 1'b0;
         w0[27] = bad;
         exp_mem[d] = w0;
         allow[d] = 1; allow[d+1] = 1;
      end else begin
         exp_req = 0;
      end
      stalls = 0;
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1; in_data = q[i]; in_last = (i == n-1); in_err = e && (i == n-1);
         forever begin
            #1 r = in_ready;
            @(negedge clk);
            if (r) break;
            stalls++;
         end
      end
      in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
      repeat (4) @(negedge clk);
      chk(stalls == (owned ? 5 : 3), {tag, " R12 stalls"}, stalls, owned ? 5 : 3);
      diffs = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== exp_mem[i]) diffs++;
      chk(diffs == 0, {tag, " memory image"}, diffs, 0);
      chk(rx_req == exp_req, {tag, " R10 R11 rx_req"}, {31'h0, rx_req}, {31'h0, exp_req});
      if (owned) exp_off = exp_mem[d][30] ? 0 : exp_off + 3;   // R9
   endtask

   initial begin
      logic [7:0] q[$];
      for (int i = 0; i < 1024; i++) begin exp_mem[i] = '0; allow[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R2 reset state
      chk(rx_req == 1'b0, "R2 rx_req", {31'h0, rx_req}, 0);
      chk(in_ready == 1'b0, "R2 in_ready", {31'h0, in_ready}, 0);
      chk(mem_en == 1'b0, "R2 mem_en", {31'h0, mem_en}, 0);

      // R1 layout: flags, capacity/length, buffer byte address
      put(BASE+0, 32'h8000_0000); put(BASE+1, {16'd64, 16'h0}); put(BASE+2, 32'h0000_0400);
      put(BASE+3, 32'h8000_00A5); put(BASE+4, {16'd6, 16'h0});  put(BASE+5, 32'h0000_0513);
      put(BASE+6, 32'hC000_0000); put(BASE+7, {16'd32, 16'h0}); put(BASE+8, 32'h0000_0600);
      put(321, 32'hDEAD_BEEF); put(322, 32'hDEAD_BEEF);
      pulse_set();
      #1 chk(rx_req == 1'b1, "R11 set", {31'h0, rx_req}, 1);

      q.delete(); for (int i = 0; i < 9; i++) q.push_back(8'(8'h10 + i));
      run_frame(q, 0, "R4 packing");
      q.delete(); for (int i = 0; i < 10; i++) q.push_back(8'(8'h20 + i));
      run_frame(q, 0, "R5 R8 truncate");
      q.delete(); for (int i = 0; i < 4; i++) q.push_back(8'(8'h30 + i));
      run_frame(q, 1, "R7 R9 error wrap");
      q.delete(); for (int i = 0; i < 3; i++) q.push_back(8'(8'h40 + i));
      run_frame(q, 0, "R10 drop");

      // R11: gate closed, stream held off
      in_valid = 1'b1; in_data = 8'h55; in_last = 1'b1;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); #1;
         chk(in_ready == 1'b0 && mem_en == 1'b0, "R11 gated", {30'h0, in_ready, mem_en}, 0);
      end
      in_valid = 1'b0; in_last = 1'b0;

      put(BASE+0, 32'h8000_0000); put(BASE+1, {16'd8, 16'h0});
      pulse_set();
      q.delete(); for (int i = 0; i < 8; i++) q.push_back(8'(8'h60 + i));
      run_frame(q, 0, "R6 R7 exact fit");

      pulse_clr();
      #1 chk(rx_req == 1'b0, "R11 clear", {31'h0, rx_req}, 0);
      pulse_set();
      q.delete(); for (int i = 0; i < 2; i++) q.push_back(8'(8'h70 + i));
      run_frame(q, 0, "R9 R10 pointer after wrap");

      done = 1;
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL R3 watchdog actual=running expected=finished");
         report();
         $finish;
      end
   end
endmodule